// File: doc/BRIEF.md
# SPI Master with Occupancy-Driven Chip Select

This block is a byte-wide SPI master that sits on a small register bus. Software pushes bytes into an eight-entry transmit queue by writing the data register. Each byte is shifted out MSB first in SPI mode 0, and the byte clocked in on MISO during the same eight clocks lands in an eight-entry receive queue. Reading the data register pops the oldest received byte. To read from a slave, software therefore pushes dummy bytes, one for each byte it wants back.

Software has no chip-select control. Select goes active as soon as the transmit queue holds a byte and stays active while bytes keep arriving. A transaction ends when the queue runs dry. After the last byte the shifter holds select low for one SPI clock period. A byte written in that window continues the same transaction; otherwise select is released.

Top module: `spim_auto_cs`

## Requirements
- R1: After reset, chip select is high, SCLK is low, MOSI is low and the status register reads 8'h06.
- R2: The status register is at bus address 0. Bit 0 is busy (the shifter is active, which is whenever chip select is low). Bit 1 is set while the TX queue has room. Bit 2 is set while the TX queue is empty. Bit 3 is set while the RX queue holds a byte. Bit 4 is the overflow flag. Bits 7:5 read zero.
- R3: A data write at address 1 to a full TX queue (8 bytes at the start of the cycle) is discarded and sets status bit 4. The flag stays set until reset.
- R4: Chip select goes low the cycle after an idle master finds the TX queue non-empty. It stays low across back-to-back bytes. It goes high exactly CLK_DIV cycles after the last byte ends, provided the TX queue stayed empty throughout that window.
- R5: SCLK idles low. Each bit lasts CLK_DIV cycles: a low half followed by a high half. MOSI carries the byte MSB first and changes only on the falling edge or when a byte is loaded.
- R6: MISO is sampled in the last cycle of each low half, MSB first. Every byte shifted out pushes exactly one assembled byte into the RX queue, in the last cycle of that byte.
- R7: Reading address 1 returns the oldest RX byte and removes it. A read of an empty RX queue returns 8'h00 and changes nothing.
- R8: A received byte that finds the RX queue full (8 bytes at the start of the cycle) is discarded, and the stored bytes are kept.
- R9: A byte written while select is held in the post-byte window is shifted without releasing chip select.
- R10: A received byte becomes visible no earlier than 8*CLK_DIV+1 cycles after the data write that sent it, counting from the write's clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = status, 1 = data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, selected by bus_addr |
| spi_sclk | output | 1 | Serial clock, mode 0 |
| spi_mosi | output | 1 | Serial data to the slave |
| spi_miso | input | 1 | Serial data from the slave |
| spi_cs_n | output | 1 | Active-low slave select |

## Verification
The bench targets the hold window after the last byte. It writes a byte inside that window, so a design that released select too early would split one transaction into two select pulses. It also bursts ten bytes into an idle master. A design whose full check ignored the byte being shifted out would accept the wrong number of bytes, miss the overflow flag, or overwrite stored RX data when the ninth reply arrives. The latency test samples the RX-not-empty bit in the cycles around the first reply, so an off-by-one byte counter or a sample taken on the wrong half of SCLK shows up as a wrong flag or a wrong received value.

// File: rtl/spim_pkg.sv
package spim_pkg;

  typedef enum logic [1:0] {
    SH_IDLE  = 2'd0,
    SH_SHIFT = 2'd1,
    SH_HOLD  = 2'd2
  } sh_state_e;

  localparam int ST_BUSY = 0;
  localparam int ST_TXNF = 1;
  localparam int ST_TXE  = 2;
  localparam int ST_RXNE = 3;
  localparam int ST_OVF  = 4;

  function automatic logic [7:0] pack_status(input logic busy, input logic txnf,
                                             input logic txe, input logic rxne,
                                             input logic ovf);
    logic [7:0] s;
    s          = '0;
    s[ST_BUSY] = busy;
    s[ST_TXNF] = txnf;
    s[ST_TXE]  = txe;
    s[ST_RXNE] = rxne;
    s[ST_OVF]  = ovf;
    return s;
  endfunction

endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 8,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic [CW-1:0]    level,
  output logic             full,
  output logic             empty
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wptr, rptr;
  logic [CW-1:0]    cnt;
  logic             do_push, do_pop;

  function automatic logic [PW-1:0] next_ptr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign head    = mem[rptr];
  assign level   = cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (do_push) wptr <= next_ptr(wptr);
      if (do_pop)  rptr <= next_ptr(rptr);
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= push_data;
  end

endmodule

// File: rtl/spim_shifter.sv
module spim_shifter
  import spim_pkg::*;
#(
  parameter int DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_avail,
  input  logic [7:0] tx_byte,
  output logic       tx_take,
  output logic [7:0] rx_byte,
  output logic       rx_put,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic       cs_n,
  output logic       active
);

  localparam int HALF = DIV / 2;
  localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] HALF_LAST = CW'(HALF - 1);
  localparam logic [CW-1:0] HOLD_LAST = CW'(DIV - 1);

  sh_state_e     state;
  logic [CW-1:0] half_cnt;
  logic [CW-1:0] hold_cnt;
  logic [3:0]    edge_cnt;
  logic [7:0]    tx_sh;
  logic [7:0]    rx_sh;

  logic half_end, rise_evt, fall_evt, byte_end, hold_end, load;

  assign half_end = (state == SH_SHIFT) && (half_cnt == HALF_LAST);
  assign rise_evt = half_end && !edge_cnt[0];
  assign fall_evt = half_end && edge_cnt[0];
  assign byte_end = fall_evt && (edge_cnt == 4'd15);
  assign hold_end = (state == SH_HOLD) && (hold_cnt == HOLD_LAST);
  assign load     = tx_avail && (state == SH_IDLE || state == SH_HOLD || byte_end);

  assign tx_take = load;
  assign rx_put  = byte_end;
  assign rx_byte = rx_sh;
  assign sclk    = (state == SH_SHIFT) && edge_cnt[0];
  assign mosi    = (state == SH_SHIFT) && tx_sh[7];
  assign cs_n    = (state == SH_IDLE);
  assign active  = (state != SH_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= SH_IDLE;
      half_cnt <= '0;
      hold_cnt <= '0;
      edge_cnt <= '0;
      tx_sh    <= '0;
      rx_sh    <= '0;
    end else begin
      case (state)
        SH_SHIFT: begin
          half_cnt <= half_end ? '0 : half_cnt + 1'b1;
          if (rise_evt) begin
            rx_sh    <= {rx_sh[6:0], miso};
            edge_cnt <= edge_cnt + 1'b1;
          end
          if (fall_evt) begin
            if (byte_end) begin
              state    <= SH_HOLD;
              hold_cnt <= '0;
            end else begin
              edge_cnt <= edge_cnt + 1'b1;
              tx_sh    <= {tx_sh[6:0], 1'b0};
            end
          end
        end
        SH_HOLD: begin
          if (hold_end) state <= SH_IDLE;
          else          hold_cnt <= hold_cnt + 1'b1;
        end
        default: ;
      endcase
      if (load) begin
        state    <= SH_SHIFT;
        tx_sh    <= tx_byte;
        half_cnt <= '0;
        edge_cnt <= '0;
      end
    end
  end

endmodule

// File: rtl/spim_auto_cs.sv
module spim_auto_cs
  import spim_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int CLK_DIV    = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_sel,
  input  logic       bus_we,
  input  logic       bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       spi_sclk,
  output logic       spi_mosi,
  input  logic       spi_miso,
  output logic       spi_cs_n
);

  localparam int LW = $clog2(FIFO_DEPTH + 1);

  logic          data_wr, data_rd;
  logic          tx_full, tx_empty, rx_full, rx_empty;
  logic [7:0]    tx_head, rx_head, rx_byte;
  logic [LW-1:0] tx_level, rx_level;
  logic          tx_take, byte_done, busy;
  logic          ovf_flag, ovf_evt, rx_pop_evt;

  assign data_wr    = bus_sel & bus_we & bus_addr;
  assign data_rd    = bus_sel & ~bus_we & bus_addr;
  assign ovf_evt    = data_wr & tx_full;
  assign rx_pop_evt = data_rd & ~rx_empty;

  spim_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) u_txq (
    .clk(clk), .rst_n(rst_n),
    .push(data_wr), .push_data(bus_wdata), .pop(tx_take),
    .head(tx_head), .level(tx_level), .full(tx_full), .empty(tx_empty)
  );

  spim_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) u_rxq (
    .clk(clk), .rst_n(rst_n),
    .push(byte_done), .push_data(rx_byte), .pop(data_rd),
    .head(rx_head), .level(rx_level), .full(rx_full), .empty(rx_empty)
  );

  spim_shifter #(.DIV(CLK_DIV)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .tx_avail(~tx_empty), .tx_byte(tx_head), .tx_take(tx_take),
    .rx_byte(rx_byte), .rx_put(byte_done),
    .miso(spi_miso), .sclk(spi_sclk), .mosi(spi_mosi),
    .cs_n(spi_cs_n), .active(busy)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       ovf_flag <= 1'b0;
    else if (ovf_evt) ovf_flag <= 1'b1;
  end

  assign bus_rdata = bus_addr ? (rx_empty ? 8'h00 : rx_head)
                              : pack_status(busy, ~tx_full, tx_empty, ~rx_empty, ovf_flag);

endmodule

// File: rtl/spim_auto_cs_chk.sv
module spim_auto_cs_chk #(
  parameter int DEPTH = 8,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          spi_cs_n,
  input logic          spi_sclk,
  input logic          spi_mosi,
  input logic [LW-1:0] tx_level,
  input logic [LW-1:0] rx_level,
  input logic          ovf_flag,
  input logic          byte_done,
  input logic          rx_pop_evt
);

  AST_IDLE_CLOCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk); // R5
  AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!spi_cs_n && spi_sclk) |-> $stable(spi_mosi)); // R5
  AST_DATA_SELECTS: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level != '0) |=> !spi_cs_n); // R4
  AST_RELEASE_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |-> ($past(tx_level) == '0)); // R4
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |=> ovf_flag); // R3
  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level <= LW'(DEPTH)) && (rx_level <= LW'(DEPTH))); // R8
  AST_ONE_RX_PER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && !rx_pop_evt && rx_level < LW'(DEPTH)) |=> (rx_level == $past(rx_level) + 1'b1)); // R6

endmodule

bind spim_auto_cs spim_auto_cs_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
  .spi_mosi(spi_mosi), .tx_level(tx_level), .rx_level(rx_level),
  .ovf_flag(ovf_flag), .byte_done(byte_done), .rx_pop_evt(rx_pop_evt)
);

// File: tb/spim_auto_cs_test.sv
module spim_auto_cs_test;

  localparam int DIV   = 4;
  localparam int DEPTH = 8;
  localparam int HALF  = DIV / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_we = 1'b0, bus_addr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic spi_sclk, spi_mosi, spi_cs_n;
  logic spi_miso;

  int nchecks = 0, nerr = 0, cs_rises = 0, scount = 0, falls = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  spim_auto_cs #(.FIFO_DEPTH(DEPTH), .CLK_DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .spi_cs_n(spi_cs_n)
  );

  function automatic logic [7:0] slave_pat(input int i);
    return 8'((i * 29 + 107) ^ (i << 3));
  endfunction

  // Behavioural slave: shifts its pattern out, updating on SCLK falling edges.
  initial spi_miso = slave_pat(0)[7];
  always @(negedge spi_sclk) if (rst_n) begin
    falls = falls + 1;
    if (falls == 8) begin
      falls  = 0;
      scount = scount + 1;
    end
    spi_miso = slave_pat(scount)[7 - falls];
  end

  always @(posedge spi_cs_n) if (rst_n) cs_rises = cs_rises + 1;

  // Reference model: queues and counters, advanced once per clock.
  logic [7:0] txq[$];
  logic [7:0] rxq[$];
  int mode = 0, t = 0, g = 0;
  logic [7:0] cur = 8'h00, acc = 8'h00;
  bit m_ovf = 1'b0;

  always @(posedge clk) begin
    int txn, rxn;
    bit pushrx;
    if (!rst_n) begin
      txq.delete(); rxq.delete();
      mode = 0; t = 0; g = 0; cur = 8'h00; acc = 8'h00; m_ovf = 1'b0;
    end else begin
      txn = txq.size();
      rxn = rxq.size();
      pushrx = 1'b0;
      if (mode == 0) begin
        if (txn > 0) begin cur = txq.pop_front(); mode = 1; t = 0; end
      end else if (mode == 1) begin
        if (t % DIV == HALF - 1) acc = {acc[6:0], spi_miso};
        if (t == 8 * DIV - 1) begin
          pushrx = 1'b1;
          if (txn > 0) begin cur = txq.pop_front(); t = 0; end
          else begin mode = 2; g = 0; end
        end else t = t + 1;
      end else begin
        if (txn > 0) begin cur = txq.pop_front(); mode = 1; t = 0; end
        else if (g == DIV - 1) mode = 0;
        else g = g + 1;
      end
      if (bus_sel && !bus_we && bus_addr && rxn > 0) void'(rxq.pop_front());
      if (pushrx && rxn < DEPTH) rxq.push_back(acc);
      if (bus_sel && bus_we && bus_addr) begin
        if (txn < DEPTH) txq.push_back(bus_wdata);
        else m_ovf = 1'b1;
      end
    end
  end

  function automatic logic [7:0] model_status();
    logic [7:0] s;
    s = 8'h00;
    s[0] = (mode != 0);
    s[1] = (txq.size() < DEPTH);
    s[2] = (txq.size() == 0);
    s[3] = (rxq.size() > 0);
    s[4] = m_ovf;
    return s;
  endfunction

  task automatic check(input logic [7:0] got, input logic [7:0] exp, input string tag);
    nchecks = nchecks + 1;
    if (got !== exp) begin
      nerr = nerr + 1;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // Per-cycle comparison, away from the active edge.
  always @(negedge clk) if (rst_n && !done) begin
    logic e_cs, e_sclk, e_mosi;
    logic [7:0] e_rd;
    e_cs   = (mode == 0);
    e_sclk = (mode == 1) && ((t / HALF) % 2 == 1);
    e_mosi = (mode == 1) ? cur[7 - (t / DIV)] : 1'b0;
    e_rd   = bus_addr ? ((rxq.size() > 0) ? rxq[0] : 8'h00) : model_status();
    check({7'd0, spi_cs_n}, {7'd0, e_cs},   "R4 cs_n");
    check({7'd0, spi_sclk}, {7'd0, e_sclk}, "R5 sclk");
    check({7'd0, spi_mosi}, {7'd0, e_mosi}, "R5 mosi");
    check(bus_rdata, e_rd, bus_addr ? "R7 data read" : "R2 status");
  end

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", nerr, nchecks);
      $finish;
    end
  endtask

  task automatic bus_write(input logic [7:0] v);
    @(negedge clk); #1;
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 1'b1; bus_wdata = v;
    @(negedge clk); #1;
    bus_sel = 1'b0; bus_we = 1'b0; bus_addr = 1'b0;
  endtask

  task automatic bus_burst(input int n);
    @(negedge clk); #1;
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 1'b1; bus_wdata = 8'h80;
    for (int i = 1; i < n; i++) begin
      @(negedge clk); #1;
      bus_wdata = 8'h80 + 8'(i);
    end
    @(negedge clk); #1;
    bus_sel = 1'b0; bus_we = 1'b0; bus_addr = 1'b0;
  endtask

  task automatic bus_read(output logic [7:0] v);
    @(negedge clk); #1;
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 1'b1;
    #1 v = bus_rdata;
    @(negedge clk); #1;
    bus_sel = 1'b0; bus_addr = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (2) @(negedge clk);
    while (spi_cs_n !== 1'b1) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (10000) @(posedge clk);
    if (!done) begin
      nchecks = nchecks + 1;
      nerr = nerr + 1;
      $display("FAIL watchdog: got timeout expected completion");
      finish_up();
    end
  end

  initial begin
    logic [7:0] v;
    int base, r0;
    repeat (3) @(posedge clk);
    @(negedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    check(bus_rdata, 8'h06, "R1 reset status");
    check({7'd0, spi_cs_n}, 8'h01, "R1 reset cs_n");
    check({6'd0, spi_sclk, spi_mosi}, 8'h00, "R1 reset sclk/mosi");

    // Single byte: reply latency, read-back, empty read.
    base = scount; r0 = cs_rises;
    bus_write(8'hA5);
    repeat (8 * DIV) @(negedge clk);
    check({7'd0, bus_rdata[3]}, 8'h00, "R10 rx flag before byte end");
    @(negedge clk);
    check({7'd0, bus_rdata[3]}, 8'h01, "R10 rx flag after byte end");
    wait_idle();
    check(8'(cs_rises - r0), 8'd1, "R4 one select pulse");
    bus_read(v);
    check(v, slave_pat(base), "R6 received byte");
    bus_read(v);
    check(v, 8'h00, "R7 empty read");
    @(negedge clk);
    check(bus_rdata, 8'h06, "R7 status after drain");

    // Write during the hold window keeps select low.
    base = scount; r0 = cs_rises;
    bus_write(8'h11);
    repeat (8 * DIV) @(negedge clk);
    bus_write(8'h22);
    wait_idle();
    check(8'(cs_rises - r0), 8'd1, "R9 no release in hold window");
    bus_read(v);
    check(v, slave_pat(base), "R9 first byte");
    bus_read(v);
    check(v, slave_pat(base + 1), "R9 second byte");

    // Back-to-back burst of three.
    base = scount; r0 = cs_rises;
    bus_burst(3);
    wait_idle();
    check(8'(cs_rises - r0), 8'd1, "R4 burst single select");
    for (int i = 0; i < 3; i++) begin
      bus_read(v);
      check(v, slave_pat(base + i), "R7 burst order");
    end

    // Ten writes into an idle master: one dropped, RX overflows by one.
    base = scount;
    bus_burst(10);
    @(negedge clk);
    check({7'd0, bus_rdata[4]}, 8'h01, "R3 overflow flag");
    wait_idle();
    for (int i = 0; i < DEPTH; i++) begin
      bus_read(v);
      check(v, slave_pat(base + i), "R8 kept bytes");
    end
    bus_read(v);
    check(v, 8'h00, "R8 ninth reply dropped");
    bus_write(8'h5E);
    wait_idle();
    check({7'd0, bus_rdata[4]}, 8'h01, "R3 overflow sticky");
    bus_read(v);
    check(v, slave_pat(base + 9), "R3 exactly nine accepted");

    finish_up();
  end

endmodule